// File: doc/BRIEF.md
# Opcode-Controlled Integer ALU

This block is a purely combinational integer arithmetic-logic unit. It takes two operands and a 4-bit operation code, and it returns a result word plus three flags: zero, signed overflow and carry-out. It supports six operations:

- bitwise AND, OR and NOR
- addition and subtraction
- signed set-on-less-than

It sits in an execute stage. The register-file operands come in, and the opcode comes from the instruction decoder.

Inside, the opcode is not decoded into one-hot strobes. Its upper two bits feed straight into the datapath:

- bit 3 inverts the A operand;
- bit 2 inverts the B operand, and the same bit is the carry into the lowest bit.

The lower two bits pick which per-bit output appears on the result. With this arrangement a single ripple-carry chain of identical bit slices serves every operation. NOR is AND with both operands inverted. Subtraction and comparison reuse the adder with B negated.

Top module: `int_alu`

## Requirements
- R1: Opcode 4'b0000 gives result = opA & opB, with ovfFlag and carryOut at 0.
- R2: Opcode 4'b0001 gives result = opA | opB, with ovfFlag and carryOut at 0.
- R3: Opcode 4'b1100 gives result = ~(opA | opB), with ovfFlag and carryOut at 0.
- R4: Opcode 4'b0010 gives result = (opA + opB) mod 2^WIDTH. carryOut is the unsigned carry out of the top bit.
- R5: Opcode 4'b0110 gives result = (opA - opB) mod 2^WIDTH. This is formed as opA + ~opB + 1, so carryOut is 1 exactly when opA >= opB as unsigned numbers.
- R6: Opcode 4'b0111 gives a result whose bit 0 is 1 exactly when opA < opB as two's-complement numbers, and whose bits WIDTH-1..1 are 0. The comparison stays correct when the internal subtraction overflows. carryOut is the carry of opA - opB.
- R7: For opcodes 0010, 0110 and 0111, ovfFlag is 1 exactly when the signed add (0010) or signed subtract (0110, 0111) overflows. This equals the carry into the top bit XOR the carry out of it.
- R8: For the logic opcodes 0000, 0001 and 1100, ovfFlag and carryOut are both 0.
- R9: For every listed opcode, zeroFlag is 1 exactly when all result bits are 0.
- R10: Any other opcode gives result 0 with zeroFlag, ovfFlag and carryOut all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| zeroFlag | output | 1 | Result is all zeros (listed opcodes only) |
| ovfFlag | output | 1 | Signed overflow of the arithmetic operation |
| carryOut | output | 1 | Carry out of the most significant bit |

## Verification
The block holds no state, so any wrong internal value shows up at the ports in the same evaluation as the input that exposes it:

- A broken carry link corrupts the upper result bits.
- A bad carry link also flips carryOut or ovfFlag as soon as a carry has to travel past that bit.
- A wrong decode of the invert or mux bits gives a wrong logic function, or stray flags.

A 4-bit copy of the block is swept over every opcode and operand pair. The 32-bit copy is driven with the extreme values and random operands, so that a fault which only shows at the sign boundary, or in a long carry chain, is caught.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  localparam logic [1:0] SEL_AND  = 2'd0;
  localparam logic [1:0] SEL_OR   = 2'd1;
  localparam logic [1:0] SEL_SUM  = 2'd2;
  localparam logic [1:0] SEL_LESS = 2'd3;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic       aInvert;
    logic       bNegate;
    logic [1:0] outSel;
    logic       arith;
    logic       legal;
  } alu_ctrl_t;

endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl.aInvert = opSel[3];
    ctrl.bNegate = opSel[2];
    ctrl.outSel  = opSel[1:0];
    ctrl.arith   = 1'b0;
    ctrl.legal   = 1'b0;
    case (opSel)
      OP_AND, OP_OR, OP_NOR: ctrl.legal = 1'b1;
      OP_ADD, OP_SUB, OP_SLT: begin
        ctrl.legal = 1'b1;
        ctrl.arith = 1'b1;
      end
      default: begin
        ctrl.legal = 1'b0;
        ctrl.arith = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/int_alu_bitslice.sv
module int_alu_bitslice
  import int_alu_pkg::*;
(
  input  logic       aBit,
  input  logic       bBit,
  input  logic       carryIn,
  input  logic       aInvert,
  input  logic       bNegate,
  input  logic [1:0] outSel,
  input  logic       lessIn,
  output logic       resBit,
  output logic       carryOutBit
);

  logic aEff;
  logic bEff;
  logic sumBit;

  assign aEff        = aBit ^ aInvert;
  assign bEff        = bBit ^ bNegate;
  assign sumBit      = aEff ^ bEff ^ carryIn;
  assign carryOutBit = (aEff & bEff) | (aEff & carryIn) | (bEff & carryIn);

  always_comb begin
    case (outSel)
      SEL_AND: resBit = aEff & bEff;
      SEL_OR:  resBit = aEff | bEff;
      SEL_SUM: resBit = sumBit;
      default: resBit = lessIn;
    endcase
  end

endmodule

// File: rtl/int_alu_datapath.sv
module int_alu_datapath
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag,
  output logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sliceRes;
  logic [WIDTH-1:0] lessVec;
  logic             rawOvf;
  logic             msbSum;
  logic             setBit;

  assign carry[0] = ctrl.bNegate;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      int_alu_bitslice u_slice (
        .aBit        (opA[i]),
        .bBit        (opB[i]),
        .carryIn     (carry[i]),
        .aInvert     (ctrl.aInvert),
        .bNegate     (ctrl.bNegate),
        .outSel      (ctrl.outSel),
        .lessIn      (lessVec[i]),
        .resBit      (sliceRes[i]),
        .carryOutBit (carry[i+1])
      );
    end
  endgenerate

  assign rawOvf = carry[MSB] ^ carry[WIDTH];
  assign msbSum = (opA[MSB] ^ ctrl.aInvert) ^ (opB[MSB] ^ ctrl.bNegate) ^ carry[MSB];
  assign setBit = msbSum ^ rawOvf;

  always_comb begin
    lessVec    = '0;
    lessVec[0] = setBit;
  end

  assign result   = ctrl.legal ? sliceRes : '0;
  assign zeroFlag = ctrl.legal & ~(|sliceRes);
  assign ovfFlag  = ctrl.arith & rawOvf;
  assign carryOut = ctrl.arith & carry[WIDTH];

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovfFlag,
  output logic             carryOut
);

  alu_ctrl_t ctrl;

  int_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  int_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .zeroFlag (zeroFlag),
    .ovfFlag  (ovfFlag),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             ovfFlag,
  input logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic known;
  logic logicOp;
  logic legalOp;

  assign known   = !$isunknown({opA, opB, opSel});
  assign logicOp = (opSel == 4'b0000) || (opSel == 4'b0001) || (opSel == 4'b1100);
  assign legalOp = logicOp || (opSel == 4'b0010) || (opSel == 4'b0110) || (opSel == 4'b0111);

  always_comb begin
    if (known) begin
      if (opSel == 4'b0000) AST_AND_RESULT: assert (result == (opA & opB)) else $error("and mismatch"); // R1
      if (opSel == 4'b0001) AST_OR_RESULT: assert (result == (opA | opB)) else $error("or mismatch"); // R2
      if (opSel == 4'b1100) AST_NOR_RESULT: assert (result == ~(opA | opB)) else $error("nor mismatch"); // R3
      if (opSel == 4'b0010) AST_ADD_RESULT: assert (result == opA + opB) else $error("add mismatch"); // R4
      if (opSel == 4'b0110) AST_SUB_RESULT: assert (result == opA - opB) else $error("sub mismatch"); // R5
      if (opSel == 4'b0111) AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0) else $error("slt upper bits"); // R6
      if (opSel == 4'b0110) AST_SUB_OVERFLOW: assert (ovfFlag == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB]))) else $error("sub overflow"); // R7
      if (logicOp) AST_LOGIC_NO_FLAGS: assert (!ovfFlag && !carryOut) else $error("logic flags"); // R8
      if (legalOp) AST_ZERO_MATCH: assert (zeroFlag == (result == '0)) else $error("zero flag"); // R9
      if (!legalOp) AST_ILLEGAL_QUIET: assert (result == '0 && !zeroFlag && !ovfFlag && !carryOut) else $error("illegal op"); // R10
    end
  end

endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .opA      (opA),
  .opB      (opB),
  .opSel    (opSel),
  .result   (result),
  .zeroFlag (zeroFlag),
  .ovfFlag  (ovfFlag),
  .carryOut (carryOut)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;

  localparam int WIDE   = 32;
  localparam int NARROW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [WIDE-1:0]   wA, wB, wRes;
  logic [3:0]        wOp;
  logic              wZero, wOvf, wCy;
  logic [NARROW-1:0] nA, nB, nRes;
  logic [3:0]        nOp;
  logic              nZero, nOvf, nCy;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  int_alu #(.WIDTH(WIDE)) u_int_alu (
    .opA(wA), .opB(wB), .opSel(wOp),
    .result(wRes), .zeroFlag(wZero), .ovfFlag(wOvf), .carryOut(wCy)
  );

  int_alu #(.WIDTH(NARROW)) u_int_alu_narrow (
    .opA(nA), .opB(nB), .opSel(nOp),
    .result(nRes), .zeroFlag(nZero), .ovfFlag(nOvf), .carryOut(nCy)
  );

  function automatic string opTag(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b1100: return "R3";
      4'b0010: return "R4";
      4'b0110: return "R5";
      4'b0111: return "R6";
      default: return "R10";
    endcase
  endfunction

  // arithmetic reference model
  task automatic model(input int w, input longint a, input longint b, input logic [3:0] op,
                       output longint res, output bit z, output bit v, output bit c);
    longint mask = (longint'(1) << w) - 1;
    longint s;
    longint av, bv;
    bit sa, sb, sr;
    bit legal = 1'b1;
    a = a & mask;
    b = b & mask;
    sa = a[w-1];
    sb = b[w-1];
    v = 1'b0;
    c = 1'b0;
    res = 0;
    case (op)
      4'b0000: res = a & b;
      4'b0001: res = a | b;
      4'b1100: res = (~(a | b)) & mask;
      4'b0010: begin
        s = a + b;
        res = s & mask;
        c = s[w];
        sr = res[w-1];
        v = (sa == sb) && (sr != sa);
      end
      4'b0110, 4'b0111: begin
        s = a + ((~b) & mask) + 1;
        c = s[w];
        sr = s[w-1];
        v = (sa != sb) && (sr != sa);
        av = sa ? a - (longint'(1) << w) : a;
        bv = sb ? b - (longint'(1) << w) : b;
        if (op == 4'b0110) res = s & mask;
        else res = (av < bv) ? 1 : 0;
      end
      default: legal = 1'b0;
    endcase
    z = legal && (res == 0);
  endtask

  task automatic compare(input int w, input logic [3:0] op, input longint a, input longint b,
                         input longint gotRes, input bit gotZ, input bit gotV, input bit gotC);
    longint expRes;
    bit expZ, expV, expC;
    string flagTag;
    model(w, a, b, op, expRes, expZ, expV, expC);
    flagTag = (op == 4'b0010 || op == 4'b0110 || op == 4'b0111) ? "R7" : opTag(op);
    if (op == 4'b0000 || op == 4'b0001 || op == 4'b1100) flagTag = "R8";
    total++;
    if (gotRes != expRes) begin
      bad++;
      $display("FAIL %s w=%0d op=%b a=%h b=%h result got=%h exp=%h", opTag(op), w, op, a, b, gotRes, expRes);
    end
    total++;
    if (gotZ != expZ) begin
      bad++;
      $display("FAIL R9 w=%0d op=%b a=%h b=%h zero got=%0d exp=%0d", w, op, a, b, gotZ, expZ);
    end
    total++;
    if (gotV != expV) begin
      bad++;
      $display("FAIL %s w=%0d op=%b a=%h b=%h ovf got=%0d exp=%0d", flagTag, w, op, a, b, gotV, expV);
    end
    total++;
    if (gotC != expC) begin
      bad++;
      $display("FAIL %s w=%0d op=%b a=%h b=%h carry got=%0d exp=%0d", flagTag, w, op, a, b, gotC, expC);
    end
  endtask

  task automatic runWide(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    @(posedge clk);
    wA = a; wB = b; wOp = op;
    @(negedge clk);
    compare(WIDE, op, longint'(a), longint'(b), longint'(wRes), wZero, wOvf, wCy);
  endtask

  task automatic runNarrow(input logic [3:0] a, input logic [3:0] b, input logic [3:0] op);
    @(posedge clk);
    nA = a; nB = b; nOp = op;
    @(negedge clk);
    compare(NARROW, op, longint'(a), longint'(b), longint'(nRes), nZero, nOvf, nCy);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] corners [5];
    corners[0] = 32'h0000_0000;
    corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF;
    corners[3] = 32'h8000_0000;
    corners[4] = 32'hFFFF_FFFF;
    wA = '0; wB = '0; wOp = 4'b0000;
    nA = '0; nB = '0; nOp = 4'b0000;

    // initial state: zero operands under AND give zero result, zero flag set (R1, R9)
    @(negedge clk);
    compare(WIDE, 4'b0000, 0, 0, longint'(wRes), wZero, wOvf, wCy);

    // exhaustive sweep of the 4-bit copy: all opcodes (R1..R10)
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          runNarrow(4'(a), 4'(b), 4'(op));

    // 32-bit extremes: sign boundary overflow (R7), slt across overflow (R6)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          runWide(corners[i], corners[j], 4'(op));

    // 32-bit random operands, long carry chains (R4, R5)
    for (int k = 0; k < 200; k++)
      for (int op = 0; op < 16; op++)
        runWide($urandom, $urandom, 4'(op));

    // equal operands: subtract gives zero flag and carry 1 (R5, R9)
    runWide(32'h1234_5678, 32'h1234_5678, 4'b0110);

    summary();
  end

endmodule